// File: doc/BRIEF.md
# Pause Frame Transmit Controller

This block decides when a full-duplex Ethernet transmitter must emit an IEEE 802.3x PAUSE control frame, and with what quanta. It keeps a 32-bit host control word that holds a pause time, a re-check threshold code, a zero-quanta suppress bit, a transmit-flow enable and a self-clearing busy bit. It also watches a level flow-control request that comes from the FIFO layer.

Frames are requested from a downstream frame builder through a simple handshake. The block raises `pause_req` with a 16-bit `pause_quanta` value and holds both until the builder reports `pause_done`. A rising request or a host command produces a frame that carries the programmed pause time. A slot-time countdown then re-sends the frame while the request stays high. When the request falls, a zero-quanta frame releases the link partner. The slot timer counts an external per-bit-time strobe, so the same logic serves any line rate.

Top module: `pause_tx_ctrl`

## Requirements
- R1: Reads of the control word return pause time in bits 31:16, zero-quanta suppress in bit 7, threshold code in bits 5:4, transmit-flow enable in bit 1 and busy in bit 0. Every other bit (15:8, 6, 3, 2) reads 0. A write stores the writable fields.
- R2: A write with bit 0 and bit 1 both set starts one frame that carries the written pause time. Busy reads 1 from the cycle after the write until the frame's `pause_done`, and reads 0 afterwards.
- R3: Any write made while busy reads 1 is ignored in full. The control word keeps its earlier value.
- R4: While transmit-flow enable (bit 1) is 0, `pause_req` never rises. This holds for host writes, request edges and request falls.
- R5: A rising edge of `fc_req` with the enable set requests a frame whose quanta equal the programmed pause time.
- R6: When a pause-time frame completes, a countdown is loaded with the pause time. It falls by one per slot. Once it is at or below the threshold offset and `fc_req` is high, a new pause-time frame is requested. The offsets are 4 (code 00), 28 (01), 144 (10) and 256 (11) slots. With code 11 and a pause time of 256 or less, the re-send follows at once.
- R7: A slot lasts SLOT_BITS pulses of `bit_stb`. While `bit_stb` stays low, the countdown does not advance and no re-send occurs.
- R8: A falling edge of `fc_req` requests a frame with quanta 0, unless the zero-quanta suppress bit (bit 7) is 1. In that case no frame follows.
- R9: `pause_req` stays high with a stable `pause_quanta` until `pause_done`. Only one frame is outstanding at a time. An event that arrives during a frame is queued and requested after `pause_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Host write strobe for the control word |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Live control word read value |
| fc_req | input | 1 | Level flow-control request from the FIFO layer |
| bit_stb | input | 1 | One pulse per transmitted bit time |
| pause_req | output | 1 | Request to the frame builder to send a PAUSE frame |
| pause_quanta | output | 16 | Quanta value for the requested frame |
| pause_done | input | 1 | Frame builder reports that the frame has been transmitted |

## Verification
The bench times the re-send window against the threshold code. A design that mis-decodes the code, or counts cycles instead of bit strobes, re-sends too early, too late, or while `bit_stb` is stalled. It lowers `fc_req` in the middle of a frame. A design without queuing would drop the zero-quanta frame, or would corrupt the quanta of the frame in flight. It also checks the suppress bit, the disabled-enable case and writes made while busy. A wrong design would emit stray frames there or overwrite the pause time.

// File: rtl/pftc_pkg.sv
package pftc_pkg;

    localparam int QW = 16;

    typedef struct packed {
        logic [QW-1:0] pt;
        logic          dzq;
        logic [1:0]    thr;
        logic          tfe;
    } pftc_cfg_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } pftc_state_e;

    // Slots below the pause time at which the request is re-checked
    function automatic logic [QW-1:0] thr_offset(input logic [1:0] code);
        case (code)
            2'b00:   thr_offset = QW'(4);
            2'b01:   thr_offset = QW'(28);
            2'b10:   thr_offset = QW'(144);
            default: thr_offset = QW'(256);
        endcase
    endfunction

    function automatic logic [31:0] pack_word(input pftc_cfg_t c, input logic busy);
        pack_word = {c.pt, 8'h00, c.dzq, 1'b0, c.thr, 2'b00, c.tfe, busy};
    endfunction

endpackage

// File: rtl/pftc_regs.sv
module pftc_regs
    import pftc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic        host_done,
    output pftc_cfg_t   cfg,
    output logic        busy,
    output logic        host_kick,
    output logic [31:0] rdata
);
    logic accept;

    assign accept    = wr_en && !busy;
    assign host_kick = accept && wdata[0] && wdata[1];
    assign rdata     = pack_word(cfg, busy);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            busy <= 1'b0;
        end else begin
            if (accept) begin
                cfg.pt  <= wdata[31:16];
                cfg.dzq <= wdata[7];
                cfg.thr <= wdata[5:4];
                cfg.tfe <= wdata[1];
            end
            if (host_kick)
                busy <= 1'b1;
            else if (host_done)
                busy <= 1'b0;
        end
    end

    // R3
    wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> $stable(cfg));

    // R2
    busy_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(host_done));

endmodule

// File: rtl/pftc_slot_timer.sv
module pftc_slot_timer
    import pftc_pkg::*;
#(
    parameter int SLOT_BITS = 512
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_stb,
    input  logic          load,
    input  logic          stop,
    input  logic [QW-1:0] load_val,
    input  logic [1:0]    thr_code,
    input  logic          fc_req,
    output logic          resend
);
    localparam int SC_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
    localparam logic [SC_W-1:0] SC_LAST = SC_W'(SLOT_BITS - 1);

    logic [SC_W-1:0] slot_cnt;
    logic            slot_tick;
    logic [QW-1:0]   remain;
    logic            armed;
    logic            at_thr;

    assign slot_tick = bit_stb && (slot_cnt == SC_LAST);
    assign at_thr    = armed && (remain <= thr_offset(thr_code));
    assign resend    = at_thr && fc_req;

    always_ff @(posedge clk) begin
        if (rst)
            slot_cnt <= '0;
        else if (bit_stb)
            slot_cnt <= (slot_cnt == SC_LAST) ? '0 : slot_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            remain <= '0;
        end else if (load) begin
            armed  <= 1'b1;
            remain <= load_val;
        end else if (stop || resend) begin
            armed  <= 1'b0;
        end else if (armed && slot_tick) begin
            if (remain == '0)
                armed <= 1'b0;
            else
                remain <= remain - 1'b1;
        end
    end

    // R7
    slot_bound_chk: assert property (@(posedge clk) disable iff (rst)
        slot_cnt <= SC_LAST);

    // R7
    no_stb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !bit_stb && !load) |=> $stable(remain));

endmodule

// File: rtl/pftc_sched.sv
module pftc_sched
    import pftc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  pftc_cfg_t     cfg,
    input  logic          fc_req,
    input  logic          host_kick,
    input  logic          resend,
    input  logic          pause_done,
    output logic          pause_req,
    output logic [QW-1:0] pause_quanta,
    output logic          host_done,
    output logic          done_pt,
    output logic          done_zero
);
    pftc_state_e state;
    logic fc_q, fc_rise, fc_fall;
    logic host_pend, auto_pend, zq_pend;
    logic cur_host, cur_zero;
    logic issue, want_pt, finish;

    assign fc_rise   = fc_req && !fc_q;
    assign fc_fall   = !fc_req && fc_q;
    assign want_pt   = host_pend || auto_pend;
    assign issue     = (state == ST_IDLE) && cfg.tfe && (want_pt || zq_pend);
    assign finish    = (state == ST_SEND) && pause_done;
    assign pause_req = (state == ST_SEND);
    assign host_done = finish && cur_host;
    assign done_pt   = finish && !cur_zero;
    assign done_zero = finish && cur_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            fc_q      <= 1'b0;
            host_pend <= 1'b0;
            auto_pend <= 1'b0;
            zq_pend   <= 1'b0;
        end else begin
            fc_q <= fc_req;
            if (host_kick)
                host_pend <= 1'b1;
            else if (issue)
                host_pend <= 1'b0;

            if (!cfg.tfe || fc_fall)
                auto_pend <= 1'b0;
            else if (fc_rise || resend)
                auto_pend <= 1'b1;
            else if (issue)
                auto_pend <= 1'b0;

            if (!cfg.tfe || fc_rise)
                zq_pend <= 1'b0;
            else if (fc_fall && !cfg.dzq)
                zq_pend <= 1'b1;
            else if (issue)
                zq_pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            pause_quanta <= '0;
            cur_host     <= 1'b0;
            cur_zero     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (issue) begin
                    state        <= ST_SEND;
                    pause_quanta <= want_pt ? cfg.pt : '0;
                    cur_host     <= host_pend;
                    cur_zero     <= !want_pt;
                end
                ST_SEND: if (pause_done) begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pause_req && !pause_done) |=> pause_req);

    // R9
    quanta_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (pause_req && !pause_done) |=> $stable(pause_quanta));

    // R4
    no_send_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pause_req) |-> $past(cfg.tfe));

endmodule

// File: rtl/pause_tx_ctrl.sv
module pause_tx_ctrl
    import pftc_pkg::*;
#(
    parameter int SLOT_BITS = 512
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr_en,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          fc_req,
    input  logic          bit_stb,
    output logic          pause_req,
    output logic [QW-1:0] pause_quanta,
    input  logic          pause_done
);
    pftc_cfg_t cfg;
    logic busy, host_kick, host_done;
    logic resend, done_pt, done_zero;

    pftc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .wdata     (reg_wdata),
        .host_done (host_done),
        .cfg       (cfg),
        .busy      (busy),
        .host_kick (host_kick),
        .rdata     (reg_rdata)
    );

    pftc_slot_timer #(.SLOT_BITS(SLOT_BITS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .bit_stb  (bit_stb),
        .load     (done_pt),
        .stop     (done_zero),
        .load_val (cfg.pt),
        .thr_code (cfg.thr),
        .fc_req   (fc_req),
        .resend   (resend)
    );

    pftc_sched u_sched (
        .clk          (clk),
        .rst          (rst),
        .cfg          (cfg),
        .fc_req       (fc_req),
        .host_kick    (host_kick),
        .resend       (resend),
        .pause_done   (pause_done),
        .pause_req    (pause_req),
        .pause_quanta (pause_quanta),
        .host_done    (host_done),
        .done_pt      (done_pt),
        .done_zero    (done_zero)
    );

endmodule

// File: tb/pause_tx_ctrl_tb.sv
module pause_tx_ctrl_tb;
    localparam int SB = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        fc_req;
    logic        bit_stb;
    logic        pause_req;
    logic [15:0] pause_quanta;
    logic        pause_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pause_tx_ctrl #(.SLOT_BITS(SB)) u_dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fc_req(fc_req), .bit_stb(bit_stb),
        .pause_req(pause_req), .pause_quanta(pause_quanta), .pause_done(pause_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // waits up to n cycles for pause_req; returns cycles waited (n+1 if none)
    task automatic wait_req(input int n, output int waited);
        waited = n + 1;
        for (int i = 0; i <= n; i++) begin
            if (pause_req) begin
                waited = i;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic finish_frame();
        pause_done = 1'b1;
        @(negedge clk);
        pause_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset word", reg_rdata, 32'h0);
        chk("R9 reset req", {31'b0, pause_req}, 32'h0);
    endtask

    task automatic t_layout();
        wr(32'hFFFF_FFFE);
        chk("R1 reserved bits zero", reg_rdata, 32'hFFFF_00B2);
        wr(32'h1234_0012);
        chk("R1 field readback", reg_rdata, 32'h1234_0012);
    endtask

    task automatic t_host();
        int w;
        wr(32'h0040_0003);
        chk("R2 busy set", {31'b0, reg_rdata[0]}, 32'h1);
        wait_req(5, w);
        chk("R2 req raised", {31'b0, pause_req}, 32'h1);
        chk("R2 quanta pt", {16'b0, pause_quanta}, 32'h40);
        wr(32'h0099_00B2);
        chk("R3 write ignored", reg_rdata, 32'h0040_0003);
        repeat (5) @(negedge clk);
        chk("R9 req held", {31'b0, pause_req}, 32'h1);
        chk("R2 busy held", {31'b0, reg_rdata[0]}, 32'h1);
        finish_frame();
        chk("R2 busy cleared", {31'b0, reg_rdata[0]}, 32'h0);
        wait_req(20, w);
        chk("R2 single frame", {31'b0, pause_req}, 32'h0);
    endtask

    task automatic t_disabled();
        int w;
        wr(32'h0010_0001);
        chk("R4 no busy when disabled", {31'b0, reg_rdata[0]}, 32'h0);
        fc_req = 1'b1;
        wait_req(20, w);
        fc_req = 1'b0;
        wait_req(20, w);
        chk("R4 no frame when disabled", {31'b0, pause_req}, 32'h0);
    endtask

    task automatic t_threshold();
        int w;
        wr(32'h000A_0002);           // pt 10, code 00, enable
        fc_req = 1'b1;
        wait_req(5, w);
        chk("R5 rise frame", {31'b0, pause_req}, 32'h1);
        chk("R5 rise quanta", {16'b0, pause_quanta}, 32'hA);
        finish_frame();
        wait_req(60, w);
        // 6 slots of 4 strobes plus pipeline: 22..28 cycles
        chk("R6 resend in window", {31'b0, (w >= 18 && w <= 32)}, 32'h1);
        chk("R6 resend quanta", {16'b0, pause_quanta}, 32'hA);
        finish_frame();
        bit_stb = 1'b0;
        wait_req(100, w);
        chk("R7 no advance without strobe", {31'b0, pause_req}, 32'h0);
        bit_stb = 1'b1;
        wait_req(40, w);
        chk("R7 resumes with strobe", {31'b0, pause_req}, 32'h1);
        finish_frame();
        fc_req = 1'b0;
        wait_req(5, w);
        chk("R8 zero frame", {31'b0, pause_req}, 32'h1);
        chk("R8 zero quanta", {16'b0, pause_quanta}, 32'h0);
        finish_frame();
        wait_req(60, w);
        chk("R8 no resend after zero", {31'b0, pause_req}, 32'h0);
    endtask

    task automatic t_dzq();
        int w;
        wr(32'h000A_0082);
        fc_req = 1'b1;
        wait_req(5, w);
        finish_frame();
        fc_req = 1'b0;
        wait_req(50, w);
        chk("R8 suppressed zero frame", {31'b0, pause_req}, 32'h0);
    endtask

    task automatic t_queue_code3();
        int w;
        wr(32'h0100_0032);           // pt 0x100, code 11
        fc_req = 1'b1;
        wait_req(5, w);
        chk("R5 quanta 0x100", {16'b0, pause_quanta}, 32'h100);
        finish_frame();
        wait_req(8, w);
        chk("R6 code 11 immediate resend", {31'b0, (w <= 6)}, 32'h1);
        fc_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 frame kept on fall", {16'b0, pause_quanta}, 32'h100);
        chk("R9 req kept on fall", {31'b0, pause_req}, 32'h1);
        finish_frame();
        wait_req(5, w);
        chk("R9 queued zero frame", {31'b0, pause_req}, 32'h1);
        chk("R9 queued zero quanta", {16'b0, pause_quanta}, 32'h0);
        finish_frame();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        reg_wr_en = 1'b0;
        reg_wdata = '0;
        fc_req = 1'b0;
        bit_stb = 1'b1;
        pause_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_layout();
        t_host();
        t_disabled();
        t_threshold();
        t_dzq();
        t_queue_code3();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule